// File: doc/BRIEF.md
# GF(2) Polynomial Multiplier

This block multiplies two binary polynomials, each of `WIDTH` coefficients, and returns their product. Bit i of an operand is the coefficient of x^i. Partial products are combined with exclusive-OR instead of addition, so no carries propagate between columns. The result is therefore the carry-less (GF(2)) product and not the integer product. Such products are the core step in CRC folding, Galois-field hashing and finite-field arithmetic. Reduction modulo a field polynomial is left to a downstream stage.

The full product is computed in one combinational pass over every bit of the second operand. It is captured in an output register on the clock edge that samples an asserted input valid. The output valid is the input valid delayed by one cycle, so a new pair of operands can be accepted on every clock. Between accepted operands the product register holds its last value.

Top module: `gf2_poly_mult`

## Requirements
- R1: `product` equals the XOR, over every index i where `op_b[i]` is 1, of `op_a` shifted left by i positions. It is 2*WIDTH-1 bits wide, which is 21 bits for the default WIDTH of 11.
- R2: On the rising edge where `in_valid` is 1, `product` takes the result for the operands present at that edge, and `out_valid` goes to 1. On an edge where `in_valid` is 0, `out_valid` goes to 0. Back-to-back inputs therefore give back-to-back results.
- R3: While `in_valid` is 0, `product` keeps its value whatever the operands do.
- R4: While `rst_n` is 0, `product` and `out_valid` are both 0.
- R5: If either operand is all zeros, the captured product is all zeros.
- R6: When `op_b` equals 1 (the polynomial 1), the captured product is `op_a` zero-extended to the product width.
- R7: Exchanging `op_a` and `op_b` gives the same product.
- R8: The top product bit (x^(2*WIDTH-2)) is 1 exactly when the top bits of both operands are 1. All-ones operands produce the carry-less square of the all-ones polynomial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Operands are valid and are captured on this edge |
| op_a | input | WIDTH | First polynomial, bit i is the coefficient of x^i |
| op_b | input | WIDTH | Second polynomial, bit i is the coefficient of x^i |
| out_valid | output | 1 | Product register was loaded on the previous edge |
| product | output | 2*WIDTH-1 | Registered carry-less product |

## Verification
The hardest situation to reach from the ports is a change of operands while `in_valid` is low. It has to leave `product` untouched even though the combinational product underneath changes. The stimulus therefore follows each burst with idle cycles that drive fresh random operands, and checks on every one of those cycles that `product` still holds the last expected result. A second hard case is a stream of back-to-back inputs, where `out_valid` must stay high without a gap. It is reached by a burst with `in_valid` held high for many consecutive edges. Every expected value comes from a column-wise bit-serial model that sums a[j]&b[k-j] for each output bit k, rather than shifting `op_a`.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  // Width of a carry-less product of two w-bit polynomials.
  function automatic int unsigned prod_width(input int unsigned w);
    return 2 * w - 1;
  endfunction

endpackage

// File: rtl/clmul_pp_gen.sv
// Builds one shifted copy of op_a per bit of op_b, gated by that bit.
module clmul_pp_gen #(
  parameter int unsigned WIDTH = 11,
  localparam int unsigned PW   = clmul_pkg::prod_width(WIDTH)
) (
  input  logic [WIDTH-1:0]          op_a,
  input  logic [WIDTH-1:0]          op_b,
  output logic [WIDTH-1:0][PW-1:0]  pp
);

  localparam int unsigned PAD = PW - WIDTH;

  logic [PW-1:0] a_ext;
  assign a_ext = {{PAD{1'b0}}, op_a};

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    assign pp[i] = op_b[i] ? (a_ext << i) : '0;
  end

endmodule

// File: rtl/clmul_xor_accum.sv
// Folds the partial products together with XOR, starting from zero.
module clmul_xor_accum #(
  parameter int unsigned WIDTH = 11,
  localparam int unsigned PW   = clmul_pkg::prod_width(WIDTH)
) (
  input  logic [WIDTH-1:0][PW-1:0] pp,
  output logic [PW-1:0]            sum
);

  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      acc = acc ^ pp[i];
    end
    sum = acc;
  end

endmodule

// File: rtl/clmul_out_reg.sv
// Result register with a written-out load enable and a valid flag.
module clmul_out_reg #(
  parameter int unsigned PW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] d,
  output logic          q_valid,
  output logic [PW-1:0] q
);

  logic [PW-1:0] q_nxt;
  logic          v_nxt;

  always_comb begin
    q_nxt = q;
    if (load) begin
      q_nxt = d;
    end
    v_nxt = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q       <= q_nxt;
      q_valid <= v_nxt;
    end
  end

endmodule

// File: rtl/gf2_poly_mult.sv
module gf2_poly_mult #(
  parameter int unsigned WIDTH = 11,
  localparam int unsigned PW   = clmul_pkg::prod_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic [PW-1:0]    product
);

  logic [WIDTH-1:0][PW-1:0] pp;
  logic [PW-1:0]            comb_prod;

  clmul_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .op_a (op_a),
    .op_b (op_b),
    .pp   (pp)
  );

  clmul_xor_accum #(.WIDTH(WIDTH)) u_acc (
    .pp  (pp),
    .sum (comb_prod)
  );

  clmul_out_reg #(.PW(PW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d       (comb_prod),
    .q_valid (out_valid),
    .q       (product)
  );

  // R2: output valid is the input valid one cycle later
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: no capture means no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  // R5: a zero factor gives a zero product
  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_a == '0 || op_b == '0)) |=> (product == '0));

  // R6: multiplying by the polynomial 1
  a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_b == WIDTH'(1)) |=>
      (product == {{(PW-WIDTH){1'b0}}, $past(op_a)}));

  // R8: leading coefficient of the product
  a_r8_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (product[PW-1] == ($past(op_a[WIDTH-1]) & $past(op_b[WIDTH-1]))));

endmodule

// File: tb/gf2_poly_mult_bench.sv
`timescale 1ns/1ps
module gf2_poly_mult_bench;

  localparam int W  = 11;
  localparam int PW = 2 * W - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  op_a;
  logic [W-1:0]  op_b;
  logic          out_valid;
  logic [PW-1:0] product;

  int n_checks = 0;
  int n_fail   = 0;

  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] last_prod;
  bit            mon_on = 1'b0;

  always #4 clk = ~clk;

  gf2_poly_mult #(.WIDTH(W)) u_gf2_poly_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  // Column-wise bit-serial reference: bit k = XOR over j of a[j] & b[k-j].
  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] r;
    r = '0;
    for (int k = 0; k < PW; k++) begin
      logic bitv;
      bitv = 1'b0;
      for (int j = 0; j < W; j++) begin
        if (k - j >= 0 && k - j < W) bitv = bitv ^ (a[j] & b[k-j]);
      end
      r[k] = bitv;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    exp_q.push_back(ref_mul(a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = W'($urandom);
      op_b = W'($urandom);
    end
  endtask

  // Monitor: samples 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && rst_n) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2: actual out_valid=1 expected 0 (no pending result)");
          end else begin
            logic [PW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, product, e);
            last_prod = e;
          end
        end else begin
          if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2: actual out_valid=0 expected 1");
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end
          check("R3", product, last_prod);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    last_prod = '0;
    repeat (3) @(negedge clk);
    check("R4", product, '0);
    check("R4", {{(PW-1){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R1: directed: (x+1)*(x+1) = x^2+1 with no carry
    drive("R1", W'(3), W'(3));
    check("R1", ref_mul(W'(3), W'(3)), PW'(5));
    drive("R1", W'(11'h5A3), W'(11'h0F1));
    for (int i = 0; i < 30; i++) drive("R1", W'($urandom), W'($urandom));
    idle(3);

    // R5: zero operands
    drive("R5", '0, W'($urandom));
    drive("R5", W'($urandom) | W'(1), '0);
    drive("R5", '0, '0);
    idle(2);

    // R6: identity
    drive("R6", W'(11'h7FF), W'(1));
    check("R6", ref_mul(W'(11'h2C5), W'(1)), PW'(11'h2C5));
    drive("R6", W'(11'h2C5), W'(1));
    idle(2);

    // R7: commutativity, both orders
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      drive("R7", a, b);
      drive("R7", b, a);
    end
    idle(2);

    // R8: top coefficients
    drive("R8", '1, '1);
    drive("R8", W'(1) << (W-1), W'(1) << (W-1));
    drive("R8", W'(1) << (W-1), W'(11'h3FF));
    idle(2);

    // R2: long back-to-back burst
    for (int i = 0; i < 20; i++) drive("R2", W'($urandom), W'($urandom));
    // R3: idle with moving operands
    idle(10);

    // R4: reset after a nonzero result
    drive("R4", W'(11'h155), W'(11'h0AA));
    idle(2);
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4", product, '0);
    check("R4", {{(PW-1){1'b0}}, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    last_prod = '0;
    mon_on = 1'b1;
    idle(3);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: actual %0d results pending expected 0", exp_q.size());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule